// File: doc/BRIEF.md
# AES Key-Schedule Step Unit

This unit computes one step of the AES key schedule for a vector instruction. Each operand vector holds up to `MAXG` element groups. A group is 128 bits wide and is seen as four 32-bit words. Word 0 is the least significant word of the group, and byte 0 is the least significant byte of each word.

The unit has two operations:
- **AES-128 step.** It turns the current round-key group into the group for the next round.
- **AES-256 half-step.** It combines the two most recent groups: the older group arrives on the destination operand and the newer one on the source operand.

The control inputs are:
- a 4-bit round immediate;
- an operation select;
- the current vector length (vl), the maximum vector length (VLMAX) and the element width (SEW), which are checked for legality.

The unit takes one instruction at a time through a valid/ready handshake. It then returns one result per cycle, one for each element group, each tagged with its group index. An instruction that breaks the group rules produces a single response flagged illegal, with no writeback.

Neither latency nor logic path depends on key values. The S-box is evaluated for every byte on every cycle. The number of result cycles depends only on vl. A full AES-128 expansion is ten successive calls of the AES-128 step, with rounds 1 to 10.

Top module: `aes_keystep_unit`

## Requirements
- R1: AES-128 step (`in_op`=0). The unit takes the source group word 3 and rotates it: `{w[7:0],w[31:8]}`, so byte 1 becomes byte 0. It passes each byte through the AES S-box and XORs the round constant into byte 0, giving a temporary word T. The result words are n0 = s0^T, n1 = s1^n0, n2 = s2^n1 and n3 = s3^n2, where s is the source group.
- R2: AES-256 half-step (`in_op`=1). T is formed from source word 3. For even rounds, T is rotated, substituted and XORed with the constant rcon(round/2). For odd rounds, T is substituted only. The XOR chain of R1 then runs on the destination group in place of the source group.
- R3: For the AES-128 step, round values 1 to 10 select rcon(round), where rcon(1)=0x01 and each later constant is the previous one doubled in GF(2^8). Values 0 and 11 to 15 are used as the value XOR 8.
- R4: For the AES-256 half-step, round values 2 to 14 are used as given. Values 0, 1 and 15 are used as the value XOR 8.
- R5: `in_sew` must be 3'b010 (32-bit elements). Any other encoding gives a single response with `res_ill`=1, `res_we`=0 and `res_last`=1.
- R6: The instruction is illegal, with the same single response as R5, if any of these holds:
  - vl is not a multiple of 4;
  - VLMAX is below 4;
  - vl exceeds VLMAX;
  - vl exceeds 4*`MAXG`.
- R7: For a legal instruction accepted at clock edge k, group 0 is presented after edge k+1. Groups 0 to vl/4-1 then follow on consecutive cycles with `res_idx` counting up, and `res_last` is set on the final group. The number of cycles does not depend on the data.
- R8: `in_ready` is low while the responses of an instruction are still pending. It is high in the cycle that shows `res_last`, so the next instruction can be accepted in that same cycle.
- R9: A legal instruction with vl=0 gives a single response with `res_we`=0, `res_ill`=0 and `res_last`=1.
- R10: After reset, `res_valid`=0 and `in_ready`=1. `res_we` is never high without `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit can accept an instruction |
| in_op | input | 1 | 0 = AES-128 step, 1 = AES-256 half-step |
| in_rnd | input | 4 | Round immediate |
| in_sew | input | 3 | Element width code (3'b010 = 32 bits) |
| in_vl | input | VLW | Vector length in elements |
| in_vlmax | input | VLW | Maximum vector length in elements |
| in_vd | input | 128*MAXG | Destination operand (older key groups) |
| in_vs2 | input | 128*MAXG | Source operand (current or newer key groups) |
| res_valid | output | 1 | Response present |
| res_we | output | 1 | Response carries a group to write back |
| res_ill | output | 1 | Instruction was illegal |
| res_last | output | 1 | Final response of the instruction |
| res_idx | output | $clog2(MAXG) | Element group index of the response |
| res_group | output | 128 | New key group |

## Verification
Two things can happen in the same cycle: the last response of one instruction is presented, and the next instruction is accepted.

The bench provokes this by holding a second instruction ready and driving it in exactly the cycle in which `res_last` appears. It then checks three things:
- `in_ready` is high in that cycle;
- the next cycle carries no response;
- the following cycle presents group 0 of the second instruction with its correct key value.

A second overlap is also covered: an illegal instruction that also has a multi-group vl. Here the legality flag must win, and exactly one response must follow.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;
  localparam int EGS = 4;
  localparam int EEW = 32;
  localparam int EGW = EGS * EEW;
  localparam logic [2:0] SEW_CODE_32 = 3'b010;

  typedef enum logic {
    KS_STEP128 = 1'b0,
    KS_STEP256 = 1'b1
  } ks_op_e;

  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] x;
    acc = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = gf_dbl(x);
    end
    return acc;
  endfunction

  // round constant for index 1..10 (index 1 -> 0x01)
  function automatic logic [7:0] rcon_of(input logic [3:0] idx);
    logic [7:0] c;
    c = 8'h01;
    for (int k = 2; k <= 10; k++) begin
      if (k <= int'(idx)) c = gf_dbl(c);
    end
    return c;
  endfunction
endpackage

// File: rtl/aes_ks_sbox.sv
module aes_ks_sbox
  import aes_ks_pkg::*;
(
  input  logic [7:0] a,
  output logic [7:0] s
);
  logic [7:0] pw;
  logic [7:0] inv;

  // inverse as a^254 = product of a^(2^i), i=1..7; fixed depth for every byte
  always_comb begin
    pw  = a;
    inv = 8'h01;
    for (int i = 1; i < 8; i++) begin
      pw  = gf_mul(pw, pw);
      inv = gf_mul(inv, pw);
    end
  end

  assign s = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
           ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
endmodule

// File: rtl/aes_ks_legal.sv
module aes_ks_legal
  import aes_ks_pkg::*;
#(
  parameter int MAXG = 4,
  parameter int VLW  = 8
) (
  input  logic [2:0]     sew,
  input  logic [VLW-1:0] vl,
  input  logic [VLW-1:0] vlmax,
  output logic           illegal
);
  localparam logic [VLW-1:0] GRP_ELEMS = VLW'(EGS);
  localparam logic [VLW-1:0] CAP_ELEMS = VLW'(MAXG * EGS);

  logic bad_sew, bad_frac, bad_max, bad_over, bad_cap;

  always_comb begin
    bad_sew  = (sew != SEW_CODE_32);
    bad_frac = (vl[1:0] != 2'b00);
    bad_max  = (vlmax < GRP_ELEMS);
    bad_over = (vl > vlmax);
    bad_cap  = (vl > CAP_ELEMS);
    illegal  = bad_sew | bad_frac | bad_max | bad_over | bad_cap;
  end
endmodule

// File: rtl/aes_ks_round.sv
module aes_ks_round
  import aes_ks_pkg::*;
(
  input  ks_op_e       op,
  input  logic [3:0]   imm,
  input  logic [EGW-1:0] grp_vd,
  input  logic [EGW-1:0] grp_vs2,
  output logic [EGW-1:0] nxt
);
  logic [3:0]     rnd;
  logic           do_rot;
  logic [7:0]     rc;
  logic [EEW-1:0] last_w;
  logic [EEW-1:0] pre_w;
  logic [EEW-1:0] sub_w;
  logic [EEW-1:0] tmp_w;
  logic [EGW-1:0] base;

  // fold out-of-range immediates by flipping bit 3
  always_comb begin
    if (op == KS_STEP128) begin
      rnd    = ((imm == 4'd0) || (imm > 4'd10)) ? (imm ^ 4'h8) : imm;
      do_rot = 1'b1;
      rc     = rcon_of(rnd);
    end else begin
      rnd    = ((imm < 4'd2) || (imm > 4'd14)) ? (imm ^ 4'h8) : imm;
      do_rot = ~rnd[0];
      rc     = do_rot ? rcon_of({1'b0, rnd[3:1]}) : 8'h00;
    end
  end

  assign last_w = grp_vs2[EGW-1 -: EEW];
  assign pre_w  = do_rot ? {last_w[7:0], last_w[31:8]} : last_w;

  for (genvar b = 0; b < 4; b++) begin : g_sub
    aes_ks_sbox u_sbox (
      .a (pre_w[8*b +: 8]),
      .s (sub_w[8*b +: 8])
    );
  end

  assign tmp_w = sub_w ^ {24'h0, rc};
  assign base  = (op == KS_STEP256) ? grp_vd : grp_vs2;

  logic [EEW-1:0] chain [EGS];
  for (genvar w = 0; w < EGS; w++) begin : g_chain
    if (w == 0) begin : g_first
      assign chain[w] = base[EEW*w +: EEW] ^ tmp_w;
    end else begin : g_next
      assign chain[w] = base[EEW*w +: EEW] ^ chain[w-1];
    end
    assign nxt[EEW*w +: EEW] = chain[w];
  end
endmodule

// File: rtl/aes_keystep_unit.sv
module aes_keystep_unit
  import aes_ks_pkg::*;
#(
  parameter int MAXG = 4,
  parameter int VLW  = 8,
  localparam int VW  = MAXG * EGW,
  localparam int IW  = (MAXG > 1) ? $clog2(MAXG) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic           in_op,
  input  logic [3:0]     in_rnd,
  input  logic [2:0]     in_sew,
  input  logic [VLW-1:0] in_vl,
  input  logic [VLW-1:0] in_vlmax,
  input  logic [VW-1:0]  in_vd,
  input  logic [VW-1:0]  in_vs2,
  output logic           res_valid,
  output logic           res_we,
  output logic           res_ill,
  output logic           res_last,
  output logic [IW-1:0]  res_idx,
  output logic [EGW-1:0] res_group
);
  logic           busy;
  logic           ill_w;
  logic           ill_q;
  logic           zero_q;
  ks_op_e         op_q;
  logic [3:0]     rnd_q;
  logic [VLW-1:0] ngrp_q;
  logic [VLW-1:0] cnt_q;
  logic [VW-1:0]  vd_q;
  logic [VW-1:0]  vs2_q;
  logic [EGW-1:0] vd_g  [MAXG];
  logic [EGW-1:0] vs2_g [MAXG];
  logic [EGW-1:0] step_w;
  logic           last_w;
  logic [IW-1:0]  sel;

  aes_ks_legal #(.MAXG(MAXG), .VLW(VLW)) u_legal (
    .sew     (in_sew),
    .vl      (in_vl),
    .vlmax   (in_vlmax),
    .illegal (ill_w)
  );

  for (genvar g = 0; g < MAXG; g++) begin : g_split
    assign vd_g[g]  = vd_q[g*EGW +: EGW];
    assign vs2_g[g] = vs2_q[g*EGW +: EGW];
  end

  assign sel = cnt_q[IW-1:0];

  aes_ks_round u_round (
    .op      (op_q),
    .imm     (rnd_q),
    .grp_vd  (vd_g[sel]),
    .grp_vs2 (vs2_g[sel]),
    .nxt     (step_w)
  );

  assign in_ready = ~busy;
  assign last_w   = ill_q | zero_q | (cnt_q == ngrp_q - 1'b1);

  // operand capture: data registers carry no reset
  always_ff @(posedge clk) begin
    if (in_valid && !busy) begin
      vd_q   <= in_vd;
      vs2_q  <= in_vs2;
      op_q   <= ks_op_e'(in_op);
      rnd_q  <= in_rnd;
      ngrp_q <= in_vl >> 2;
    end
  end

  // control and registered results
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      ill_q     <= 1'b0;
      zero_q    <= 1'b0;
      cnt_q     <= '0;
      res_valid <= 1'b0;
      res_we    <= 1'b0;
      res_ill   <= 1'b0;
      res_last  <= 1'b0;
      res_idx   <= '0;
      res_group <= '0;
    end else begin
      if (busy) begin
        res_valid <= 1'b1;
        res_idx   <= sel;
        res_ill   <= ill_q;
        res_we    <= ~(ill_q | zero_q);
        res_group <= (ill_q | zero_q) ? '0 : step_w;
        res_last  <= last_w;
        if (last_w) busy <= 1'b0;
        else        cnt_q <= cnt_q + 1'b1;
      end else begin
        res_valid <= 1'b0;
        res_we    <= 1'b0;
        res_ill   <= 1'b0;
        res_last  <= 1'b0;
        if (in_valid) begin
          busy   <= 1'b1;
          cnt_q  <= '0;
          ill_q  <= ill_w;
          zero_q <= (in_vl == '0);
        end
      end
    end
  end
endmodule

// File: rtl/aes_ks_sva.sv
module aes_ks_sva #(
  parameter int VLW = 8,
  parameter int IW  = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_ready,
  input logic [2:0]     in_sew,
  input logic [VLW-1:0] in_vl,
  input logic           res_valid,
  input logic           res_we,
  input logic           res_ill,
  input logic           res_last,
  input logic [IW-1:0]  res_idx
);
  a_r5_bad_sew: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_sew != 3'b010) |-> ##2 (res_valid && res_ill && res_last));

  a_r6_vl_frac: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_vl[1:0] != 2'b00) |-> ##2 (res_valid && res_ill && !res_we));

  a_r5_ill_single: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_ill) |-> (!res_we && res_last));

  a_r7_first: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |-> ##2 (res_valid && res_idx == '0));

  a_r7_stream: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_last) |=> (res_valid && res_idx == IW'($past(res_idx) + 1'b1)));

  a_r8_busy: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_last) |-> !in_ready);

  a_r10_we_valid: assert property (@(posedge clk) disable iff (rst)
    res_we |-> res_valid);
endmodule

bind aes_keystep_unit aes_ks_sva #(.VLW(VLW), .IW(IW)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_sew    (in_sew),
  .in_vl     (in_vl),
  .res_valid (res_valid),
  .res_we    (res_we),
  .res_ill   (res_ill),
  .res_last  (res_last),
  .res_idx   (res_idx)
);

// File: tb/tb_aes_keystep_unit.sv
`timescale 1ns/1ps
module tb_aes_keystep_unit;
  localparam int MAXG = 4;
  localparam int VLW  = 8;
  localparam int VW   = MAXG * 128;
  localparam int IW   = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic           in_op = 1'b0;
  logic [3:0]     in_rnd = '0;
  logic [2:0]     in_sew = 3'b010;
  logic [VLW-1:0] in_vl = '0;
  logic [VLW-1:0] in_vlmax = '0;
  logic [VW-1:0]  in_vd = '0;
  logic [VW-1:0]  in_vs2 = '0;
  logic           res_valid, res_we, res_ill, res_last;
  logic [IW-1:0]  res_idx;
  logic [127:0]   res_group;

  always #5 clk = ~clk;

  aes_keystep_unit #(.MAXG(MAXG), .VLW(VLW)) dut (.*);

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- independent reference ----------------
  function automatic logic [7:0] rmul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = 16'h0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] rsbox(input logic [7:0] x);
    logic [7:0] inv;
    logic [7:0] s;
    inv = 8'h00;
    for (int y = 1; y < 256; y++) if (rmul(x, 8'(y)) == 8'h01) inv = 8'(y);
    for (int i = 0; i < 8; i++)
      s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1'b1);
    return s;
  endfunction

  function automatic logic [7:0] rrc(input int i);
    logic [7:0] t [10] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80, 8'h1b, 8'h36};
    return t[i-1];
  endfunction

  function automatic logic [127:0] ref_step(input bit op, input logic [3:0] imm,
                                            input logic [127:0] vd, input logic [127:0] vs2);
    int r; bit rot; logic [7:0] rc; logic [31:0] t; logic [127:0] base; logic [127:0] o;
    if (!op) begin
      r = (imm == 0 || imm > 10) ? int'(imm ^ 4'h8) : int'(imm);
      rot = 1; rc = rrc(r);
    end else begin
      r = (imm < 2 || imm > 14) ? int'(imm ^ 4'h8) : int'(imm);
      rot = (r % 2 == 0); rc = rot ? rrc(r / 2) : 8'h00;
    end
    t = vs2[127:96];
    if (rot) t = {t[7:0], t[31:8]};
    for (int b = 0; b < 4; b++) t[8*b +: 8] = rsbox(t[8*b +: 8]);
    t[7:0] = t[7:0] ^ rc;
    base = op ? vd : vs2;
    o[31:0] = base[31:0] ^ t;
    for (int w = 1; w < 4; w++) o[32*w +: 32] = base[32*w +: 32] ^ o[32*(w-1) +: 32];
    return o;
  endfunction

  function automatic logic [31:0] bsw(input logic [31:0] a);
    return {a[7:0], a[15:8], a[23:16], a[31:24]};
  endfunction

  function automatic logic [127:0] fk(input logic [31:0] a, b, c, d);
    return {bsw(d), bsw(c), bsw(b), bsw(a)};
  endfunction

  // ---------------- driver / collector ----------------
  logic [127:0] got [8];
  bit           gwe [8];
  bit           gill[8];
  int           gn;
  bit           gseq;

  task automatic run(input bit op, input logic [3:0] imm, input logic [2:0] sew,
                     input int vl, input int vlmax, input logic [VW-1:0] vd, input logic [VW-1:0] vs2);
    @(negedge clk);
    chk(in_ready === 1'b1, "R8 ready before issue", 128'(in_ready), 128'h1);
    in_valid = 1; in_op = op; in_rnd = imm; in_sew = sew;
    in_vl = VLW'(vl); in_vlmax = VLW'(vlmax); in_vd = vd; in_vs2 = vs2;
    @(negedge clk);
    in_valid = 0;
    chk(res_valid === 1'b0, "R7 no response in accept cycle", 128'(res_valid), 128'h0);
    @(negedge clk);
    gn = 0; gseq = 1;
    while (gn < 8) begin
      if (res_valid !== 1'b1) begin gseq = 0; break; end
      if (res_idx !== IW'(gn)) gseq = 0;
      got[gn] = res_group; gwe[gn] = res_we; gill[gn] = res_ill;
      gn++;
      if (res_last) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [VW-1:0] pat(input int seed);
    logic [VW-1:0] v;
    for (int w = 0; w < VW/32; w++) v[32*w +: 32] = (32'h9e3779b9 * (w + 1)) ^ (32'h01010101 * seed) ^ 32'(w << 20);
    return v;
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(res_valid === 1'b0, "R10 reset res_valid", 128'(res_valid), 128'h0);
    chk(in_ready === 1'b1, "R10 reset in_ready", 128'(in_ready), 128'h1);
    chk(res_we === 1'b0, "R10 reset res_we", 128'(res_we), 128'h0);
  endtask

  task automatic t_aes128_chain();
    logic [127:0] k, e;
    k = fk(32'h2b7e1516, 32'h28aed2a6, 32'habf71588, 32'h09cf4f3c);
    for (int r = 1; r <= 10; r++) begin
      e = ref_step(0, 4'(r), 128'h0, k);
      run(0, 4'(r), 3'b010, 4, 4, '0, {384'h0, k});
      chk(gn == 1 && gseq && gwe[0] && !gill[0], "R7 single group response", 128'(gn), 128'h1);
      chk(got[0] === e, "R1 aes128 step vs model", got[0], e);
      if (r == 1) chk(got[0] === fk(32'ha0fafe17, 32'h88542cb1, 32'h23a33939, 32'h2a6c7605),
                      "R1 round1 known vector", got[0], fk(32'ha0fafe17, 32'h88542cb1, 32'h23a33939, 32'h2a6c7605));
      k = got[0];
    end
    e = fk(32'hd014f9a8, 32'hc9ee2589, 32'he13f0cc8, 32'hb6630ca6);
    chk(k === e, "R1 R3 round10 known vector", k, e);
  endtask

  task automatic t_aes256_known();
    logic [127:0] a, b, e;
    a = fk(32'h603deb10, 32'h15ca71be, 32'h2b73aef0, 32'h857d7781);
    b = fk(32'h1f352c07, 32'h3b6108d7, 32'h2d9810a3, 32'h0914dff4);
    e = fk(32'h9ba35411, 32'h8e6925af, 32'ha51a8b5f, 32'h2067fcde);
    run(1, 4'd2, 3'b010, 4, 8, {384'h0, a}, {384'h0, b});
    chk(got[0] === e && gwe[0], "R2 aes256 even round", got[0], e);
    a = b; b = got[0];
    e = fk(32'ha8b09c1a, 32'h93d194cd, 32'hbe49846e, 32'hb75d5b9a);
    run(1, 4'd3, 3'b010, 4, 8, {384'h0, a}, {384'h0, b});
    chk(got[0] === e && gwe[0], "R2 aes256 odd round", got[0], e);
  endtask

  task automatic t_multi_group();
    logic [VW-1:0] vd, vs;
    vd = pat(3); vs = pat(7);
    run(1, 4'd6, 3'b010, 16, 16, vd, vs);
    chk(gn == 4 && gseq, "R7 four groups back to back", 128'(gn), 128'h4);
    for (int g = 0; g < 4; g++)
      chk(got[g] === ref_step(1, 4'd6, vd[128*g +: 128], vs[128*g +: 128]), "R2 group data",
          got[g], ref_step(1, 4'd6, vd[128*g +: 128], vs[128*g +: 128]));
    vd = pat(11); vs = pat(5);
    run(0, 4'd9, 3'b010, 8, 16, vd, vs);
    chk(gn == 2 && gseq, "R7 two groups other data", 128'(gn), 128'h2);
    chk(got[1] === ref_step(0, 4'd9, 128'h0, vs[255:128]), "R1 second group", got[1], ref_step(0, 4'd9, 128'h0, vs[255:128]));
  endtask

  task automatic t_imm_fold();
    logic [127:0] s, d, base;
    s = pat(21)[127:0]; d = pat(22)[127:0];
    run(0, 4'd8, 3'b010, 4, 4, '0, {384'h0, s}); base = got[0];
    run(0, 4'd0, 3'b010, 4, 4, '0, {384'h0, s});
    chk(got[0] === base, "R3 imm 0 acts as 8", got[0], base);
    run(0, 4'd4, 3'b010, 4, 4, '0, {384'h0, s}); base = got[0];
    run(0, 4'd12, 3'b010, 4, 4, '0, {384'h0, s});
    chk(got[0] === base, "R3 imm 12 acts as 4", got[0], base);
    run(1, 4'd9, 3'b010, 4, 4, {384'h0, d}, {384'h0, s}); base = got[0];
    run(1, 4'd1, 3'b010, 4, 4, {384'h0, d}, {384'h0, s});
    chk(got[0] === base && base === ref_step(1, 4'd9, d, s), "R4 imm 1 acts as 9", got[0], base);
    run(1, 4'd7, 3'b010, 4, 4, {384'h0, d}, {384'h0, s}); base = got[0];
    run(1, 4'd15, 3'b010, 4, 4, {384'h0, d}, {384'h0, s});
    chk(got[0] === base, "R4 imm 15 acts as 7", got[0], base);
    run(1, 4'd0, 3'b010, 4, 4, {384'h0, d}, {384'h0, s});
    chk(got[0] === ref_step(1, 4'd8, d, s), "R4 imm 0 acts as 8", got[0], ref_step(1, 4'd8, d, s));
  endtask

  task automatic t_illegal();
    int cases [6][3] = '{'{3, 8, 8}, '{0, 8, 8}, '{2, 6, 8}, '{2, 0, 2}, '{2, 8, 4}, '{2, 20, 32}};
    string tags [6] = '{"R5 sew 64", "R5 sew 8", "R6 vl not multiple", "R6 vlmax below 4", "R6 vl over vlmax", "R6 vl over capacity"};
    for (int c = 0; c < 6; c++) begin
      run(0, 4'd1, 3'(cases[c][0]), cases[c][1], cases[c][2], pat(1), pat(2));
      chk(gn == 1 && gill[0] && !gwe[0] && got[0] === 128'h0, tags[c], {96'h0, gn[15:0], 15'h0, gill[0], 15'h0, gwe[0]}, 128'h0000_0001_0001_0000);
    end
  endtask

  task automatic t_vl_zero();
    run(0, 4'd1, 3'b010, 0, 16, pat(1), pat(2));
    chk(gn == 1 && !gill[0] && !gwe[0] && gseq, "R9 vl zero no writeback", 128'(gn), 128'h1);
  endtask

  task automatic t_back_to_back();
    logic [VW-1:0] vs;
    int n;
    vs = pat(9);
    @(negedge clk);
    in_valid = 1; in_op = 0; in_rnd = 4'd2; in_sew = 3'b010; in_vl = 8; in_vlmax = 16; in_vd = '0; in_vs2 = vs;
    @(negedge clk);
    in_valid = 0;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (!res_last) chk(in_ready === 1'b0, "R8 not ready mid stream", 128'(in_ready), 128'h0);
    end while (!res_last && n < 8);
    chk(in_ready === 1'b1 && n == 2, "R8 ready with last response", 128'(in_ready), 128'h1);
    in_valid = 1; in_op = 1; in_rnd = 4'd5; in_vl = 4; in_vd = pat(4); in_vs2 = pat(6);
    @(negedge clk);
    in_valid = 0;
    chk(res_valid === 1'b0, "R8 gap cycle after overlap accept", 128'(res_valid), 128'h0);
    @(negedge clk);
    chk(res_valid === 1'b1 && res_idx == 0 && res_group === ref_step(1, 4'd5, pat(4)[127:0], pat(6)[127:0]),
        "R8 R7 second instruction group 0", res_group, ref_step(1, 4'd5, pat(4)[127:0], pat(6)[127:0]));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_aes128_chain();
    t_aes256_known();
    t_multi_group();
    t_imm_fold();
    t_illegal();
    t_vl_zero();
    t_back_to_back();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 128'h0, 128'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule